// File: doc/BRIEF.md
# Quadrature and Two-Pulse Position Counter

This block keeps a 32-bit position count from an incremental encoder. The encoder provides two phase inputs and an optional index input. All three pass through a common synchronizer into the system clock domain.

In the three quadrature modes, the block reads the two-bit phase word {A,B} and counts at single, double or full edge resolution. The direction follows the phase order: A leading B counts up. In two-pulse mode, A is a pure up input and B is a pure down input.

When enabled, a high index input reloads the count with a programmed value while the phase word equals a programmed phase. A start pulse loads a programmable initial value and arms counting. A sample pulse copies the live count into a held register for readout.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset, `count`, `sample_count` and `illegal_err` are zero, and encoder activity does not change `count` until the first `start` pulse.
- R2: A cycle with `start` high loads `count` from `init_val`, clears `illegal_err` and arms counting; `start` overrides every other update.
- R3: With `mode` = 2 (full resolution), every single change of A or B moves the count by one. It moves up for the phase order 00→10→11→01→00 (phase written {A,B}) and down for the reverse order.
- R4: With `mode` = 1 (double resolution), each A edge moves the count by one in the phase-order direction, and B edges have no effect.
- R5: With `mode` = 0 (single resolution), the count changes only on A edges while B is 0. A rising edge adds one and a falling edge subtracts one, which gives one step per full cycle.
- R6: In a quadrature mode, a change of both A and B between two synchronized samples leaves the count unchanged and sets `illegal_err`. The flag then stays set until the next `start`.
- R7: With `mode` = 3 (two-pulse), each rising edge of A adds one and each rising edge of B subtracts one. Falling edges have no effect.
- R8: In two-pulse mode, when A and B rise in the same synchronized sample, the count is unchanged.
- R9: In a quadrature mode with `z_en` high, a high index together with a phase word equal to `reload_phase` loads `reload_val` in place of any step. Index high in any other phase, or in two-pulse mode, has no effect.
- R10: A rising edge of `sample` copies the current `count` into `sample_count` on the following clock edge, and `sample_count` holds until the next such edge.
- R11: The count wraps modulo 2^32 in both directions.
- R12: An encoder change is reflected in `count` at most SYNC_STAGES+1 clock edges after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Loads init_val and arms counting |
| mode | input | 2 | 0 single, 1 double, 2 full quadrature, 3 two-pulse |
| enc_a | input | 1 | Encoder phase A / up pulse input |
| enc_b | input | 1 | Encoder phase B / down pulse input |
| enc_z | input | 1 | Encoder index input |
| z_en | input | 1 | Enables the index reload |
| reload_phase | input | 2 | Phase word {A,B} in which the index reloads |
| init_val | input | 32 | Value loaded by start |
| reload_val | input | 32 | Value loaded by a qualified index |
| sample | input | 1 | Rising edge latches the count |
| count | output | 32 | Live position count |
| sample_count | output | 32 | Count held at the last sample edge |
| illegal_err | output | 1 | Sticky flag for a double phase change |

## Verification
A stale previous-phase register or a wrong direction decode shows up at once as a count off by one or two. That error appears three edges after the offending encoder move and persists in every later comparison, because the count accumulates. A reload decode that fires in the wrong phase pulls the count to `reload_val` at a point where the bench expects a step. A sticky flag that leaks shows as `illegal_err` changing after legal moves, or staying high across a start. Long random walks in each mode compare the count after every single move, so a fault is localized to the move that produced it.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    MODE_X1  = 2'd0,
    MODE_X2  = 2'd1,
    MODE_X4  = 2'd2,
    MODE_TWO = 2'd3
  } qpc_mode_e;

  typedef struct packed {
    logic inc;
    logic dec;
    logic bad;
  } qpc_step_t;

  // Direction of an A move with B steady: up when new A differs from B.
  function automatic logic a_move_up(input logic a_new, input logic b_now);
    return a_new ^ b_now;
  endfunction

  // Direction of a B move with A steady: up when new B equals A.
  function automatic logic b_move_up(input logic b_new, input logic a_now);
    return ~(b_new ^ a_now);
  endfunction

  function automatic qpc_step_t decode_step(input qpc_mode_e md,
                                            input logic [1:0] prv,
                                            input logic [1:0] cur);
    qpc_step_t s;
    logic a_chg, b_chg, a_rise, b_rise, up;
    s      = '0;
    a_chg  = prv[1] ^ cur[1];
    b_chg  = prv[0] ^ cur[0];
    a_rise = cur[1] & ~prv[1];
    b_rise = cur[0] & ~prv[0];
    if (md == MODE_TWO) begin
      s.inc = a_rise & ~b_rise;
      s.dec = b_rise & ~a_rise;
    end else if (a_chg && b_chg) begin
      s.bad = 1'b1;
    end else if (a_chg) begin
      if (md == MODE_X1) begin
        if (!cur[0]) begin
          s.inc = cur[1];
          s.dec = ~cur[1];
        end
      end else begin
        up    = a_move_up(cur[1], cur[0]);
        s.inc = up;
        s.dec = ~up;
      end
    end else if (b_chg && md == MODE_X4) begin
      up    = b_move_up(cur[0], cur[1]);
      s.inc = up;
      s.dec = ~up;
    end
    return s;
  endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ab,
  input  logic       z,
  input  qpc_mode_e  mode,
  input  logic       z_en,
  input  logic [1:0] reload_phase,
  output qpc_step_t  step,
  output logic       reload_hit,
  output logic       both_rise
);
  logic [1:0] ab_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) ab_prev <= '0;
    else        ab_prev <= ab;
  end

  assign step       = decode_step(mode, ab_prev, ab);
  assign reload_hit = z & z_en & (mode != MODE_TWO) & (ab == reload_phase);
  assign both_rise  = &(ab & ~ab_prev);

  // R6
  illegal_only_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step.bad |-> (mode != MODE_TWO) && ((ab ^ ab_prev) == 2'b11));

  // R3
  single_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step.inc && step.dec));
endmodule

// File: rtl/qpc_accum.sv
module qpc_accum
  import qpc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic [W-1:0] init_val,
  input  logic [W-1:0] reload_val,
  input  qpc_step_t step,
  input  logic      reload_hit,
  output logic [W-1:0] count,
  output logic      running,
  output logic      err
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
      err     <= 1'b0;
    end else if (start) begin
      count   <= init_val;
      running <= 1'b1;
      err     <= 1'b0;
    end else if (running) begin
      if (step.bad) err <= 1'b1;
      if (reload_hit)    count <= reload_val;
      else if (step.inc) count <= count + ONE;
      else if (step.dec) count <= count - ONE;
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> count == $past(init_val) && !err);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> err);

  // R9
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && reload_hit && !start |=> count == $past(reload_val));

  // R11
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && !reload_hit && !start |=>
      ((count - $past(count)) == '0) || ((count - $past(count)) == ONE) ||
      (($past(count) - count) == ONE));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !start |=> count == '0);
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_z,
  input  logic             z_en,
  input  logic [1:0]       reload_phase,
  input  logic [CNT_W-1:0] init_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             sample,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] sample_count,
  output logic             illegal_err
);
  logic [2:0] enc_s;
  qpc_step_t  step;
  logic       reload_hit, both_rise, running, sample_q, sample_edge;
  qpc_mode_e  md;

  assign md = qpc_mode_e'(mode);

  qpc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({enc_a, enc_b, enc_z}), .q(enc_s)
  );

  qpc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ab(enc_s[2:1]), .z(enc_s[0]), .mode(md),
    .z_en(z_en), .reload_phase(reload_phase), .step(step),
    .reload_hit(reload_hit), .both_rise(both_rise)
  );

  qpc_accum #(.W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .init_val(init_val),
    .reload_val(reload_val), .step(step), .reload_hit(reload_hit),
    .count(count), .running(running), .err(illegal_err)
  );

  assign sample_edge = sample & ~sample_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_q     <= 1'b0;
      sample_count <= '0;
    end else begin
      sample_q <= sample;
      if (sample_edge) sample_count <= count;
    end
  end

  // R10
  sample_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_edge |=> sample_count == $past(count));

  // R10
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_edge |=> $stable(sample_count));

  // R8
  two_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && both_rise && md == MODE_TWO && !start |=> $stable(count));
endmodule

// File: tb/sim_quad_pos_counter.sv
module sim_quad_pos_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd2;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0, z_en = 1'b0;
  logic [1:0]  reload_phase = 2'b11;
  logic [31:0] init_val = '0, reload_val = '0;
  logic        sample = 1'b0;
  logic [31:0] count, sample_count;
  logic        illegal_err;

  int unsigned n_tests = 0, n_fail = 0;
  logic [31:0] exp_cnt = '0;
  logic        exp_err = 1'b0;

  always #2 clk = ~clk;

  quad_pos_counter u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int gpos(input logic [1:0] ab);
    case (ab)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  // Bench model of one move.
  task automatic model(input logic [1:0] o, input logic [1:0] n, input logic z);
    int d;
    d = (gpos(n) - gpos(o) + 4) % 4;
    if (mode != 2'd3 && z_en && z && n == reload_phase) begin
      exp_cnt = reload_val;
      if (d == 2) exp_err = 1'b1;
      return;
    end
    if (mode == 2'd3) begin
      if (n[1] && !o[1] && !(n[0] && !o[0])) exp_cnt++;
      else if (n[0] && !o[0] && !(n[1] && !o[1])) exp_cnt--;
    end else if (d == 2) exp_err = 1'b1;
    else if (d != 0) begin
      if (mode == 2'd2) exp_cnt = (d == 1) ? exp_cnt + 1 : exp_cnt - 1;
      else if (o[1] != n[1]) begin
        if (mode == 2'd1) exp_cnt = (d == 1) ? exp_cnt + 1 : exp_cnt - 1;
        else if (!n[0]) exp_cnt = n[1] ? exp_cnt + 1 : exp_cnt - 1;
      end
    end
  endtask

  // R12: wait SYNC_STAGES+1 edges plus margin, then compare.
  task automatic move(input logic [1:0] n, input logic z, input string req);
    logic [1:0] o;
    o = {enc_a, enc_b};
    @(negedge clk);
    {enc_a, enc_b} = n;
    enc_z = z;
    repeat (4) @(negedge clk);
    model(o, n, z);
    chk(req, count, exp_cnt);
    chk(req, {31'd0, illegal_err}, {31'd0, exp_err});
  endtask

  task automatic do_start(input logic [31:0] v);
    @(negedge clk);
    init_val = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_cnt = v;
    exp_err = 1'b0;
    @(negedge clk);
    chk("R2", count, exp_cnt);
    chk("R2", {31'd0, illegal_err}, 32'd0);
  endtask

  task automatic rand_walk(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [1:0] nx;
      if (mode == 2'd3) nx = 2'($urandom % 4);
      else nx = {enc_a, enc_b} ^ (($urandom % 2) ? 2'b10 : 2'b01);
      move(nx, 1'b0, req);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", count, 32'd0);
    chk("R1", sample_count, 32'd0);
    chk("R1", {31'd0, illegal_err}, 32'd0);
    @(negedge clk); enc_a = 1'b1; repeat (4) @(negedge clk);
    chk("R1", count, 32'd0);
    @(negedge clk); enc_a = 1'b0; repeat (4) @(negedge clk);

    mode = 2'd2;
    do_start(32'd100);
    move(2'b10, 0, "R3"); move(2'b11, 0, "R3"); move(2'b01, 0, "R3"); move(2'b00, 0, "R3");
    chk("R3", count, 32'd104);
    move(2'b01, 0, "R3"); move(2'b11, 0, "R3");
    chk("R3", count, 32'd102);
    rand_walk(200, "R3");

    mode = 2'd1;
    rand_walk(150, "R4");

    mode = 2'd0;
    do_start(32'd50);
    move({1'b1, enc_b}, 0, "R5");
    while ({enc_a, enc_b} != 2'b00) move({enc_a, enc_b} == 2'b10 ? 2'b11 :
                                         {enc_a, enc_b} == 2'b11 ? 2'b01 : 2'b00, 0, "R5");
    rand_walk(150, "R5");

    mode = 2'd2;
    do_start(32'd7);
    move({~enc_a, ~enc_b}, 0, "R6");
    chk("R6", {31'd0, illegal_err}, 32'd1);
    rand_walk(10, "R6");
    do_start(32'd7);

    mode = 2'd3;
    move(2'b00, 0, "R7");
    move(2'b10, 0, "R7"); move(2'b00, 0, "R7"); move(2'b01, 0, "R7");
    chk("R7", count, 32'd7);
    move(2'b00, 0, "R8"); move(2'b11, 0, "R8");
    chk("R8", count, 32'd7);
    rand_walk(150, "R7");

    mode = 2'd2;
    move(2'b00, 0, "R9");
    do_start(32'd20);
    z_en = 1'b1; reload_phase = 2'b11; reload_val = 32'h0000_0ABC;
    move(2'b00, 1, "R9");
    chk("R9", count, 32'd20);
    move(2'b10, 1, "R9");
    move(2'b11, 1, "R9");
    chk("R9", count, 32'h0ABC);
    move(2'b01, 0, "R9");
    chk("R9", count, 32'h0ABD);
    mode = 2'd3;
    move(2'b11, 1, "R9");
    z_en = 1'b0;
    move(2'b00, 1, "R9");
    move(2'b00, 0, "R9");

    @(negedge clk); sample = 1'b1;
    @(negedge clk); sample = 1'b0;
    @(negedge clk);
    chk("R10", sample_count, exp_cnt);
    move(2'b10, 0, "R10");
    chk("R10", sample_count, exp_cnt - 32'd1);

    mode = 2'd2;
    move(2'b00, 0, "R11");
    do_start(32'hFFFF_FFFF);
    move(2'b10, 0, "R11");
    chk("R11", count, 32'd0);
    move(2'b00, 0, "R11");
    chk("R11", count, 32'hFFFF_FFFF);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule